// File: doc/BRIEF.md
# Four-Thread Synchronous Slave FIFO Port

This block is the device side of a synchronous FIFO port that an external master controls. The master supplies the clock and a thread number, and it drives a set of active-low strobes. The strobes are chip select, write, read, output enable and packet end. The block keeps one small FIFO per thread. A write pushes the word on the data bus into the addressed thread. A read pops the head of the addressed thread into a registered output word, which the block drives back onto the bus.

Four registered flags let the master throttle its transfers. Two flags follow the thread addressed most recently: one says it is not full and the other says it is not empty. The other two flags watch fixed threads: one reports that thread 0 is full, the other that thread 1 is empty.

A packet-end strobe marks the words buffered so far on a thread as a complete short packet. A thread that fills completely counts as a full packet. A write that finds its thread full, or a read that finds it empty, changes nothing in the FIFO. It only sets a sticky error bit for that thread.

The data bus is bidirectional at the pad. The block sees it as an input word, an output word and a drive enable. Bus words are stored and returned unchanged, with byte lane 0 in bits 7:0 (little endian).

Top module: `sfifo_port`

## Requirements
- R1: After a synchronous active-high reset, every thread is empty. `flag_a`=1, `flag_b`=0, `flag_c`=0 and `flag_d`=1, all error and packet-ready bits are 0, and `dq_drive` is 0 while `cs_n` is high.
- R2: While `cs_n` is high, the write, read, output-enable and packet-end strobes have no effect on any thread, flag or output.
- R3: A rising edge with `cs_n`=0 and `wr_n`=0 pushes `dq_in` into the thread numbered `thr_sel`. Each thread returns its own words in the order they were written, and the threads are independent of each other.
- R4: A rising edge with `cs_n`=0 and `rd_n`=0 on a non-empty thread pops its head word onto `dq_out`, which is valid right after that same edge (one cycle of read latency).
- R5: `dq_drive` is 1 exactly while `cs_n`=0 and `oe_n`=0, and is 0 otherwise.
- R6: `flag_a` (not full) and `flag_b` (not empty) are registered. They describe the thread addressed at the last edge with `cs_n`=0, including any access made at that edge.
- R7: `flag_c` is 1 when thread 0 holds DEPTH words, and `flag_d` is 1 when thread 1 holds no words. Both take effect at the edge that changes the count.
- R8: A write to a full thread is dropped and the stored words stay intact. Bit i of `thr_err` is set for thread i and stays set until reset.
- R9: A read from an empty thread leaves `dq_out` and the pointers unchanged and sets that thread's bit in `thr_err`.
- R10: `pkt_end_n`=0 with `cs_n`=0 sets `pkt_rdy[thr_sel]` if that thread holds at least one word after the edge. Filling a thread to DEPTH words also sets the bit, and it clears when the thread becomes empty.
- R11: Each thread holds DEPTH (default 16) words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock supplied by the external master; rising edge active |
| rst | input | 1 | Synchronous active-high reset, empties all threads |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| oe_n | input | 1 | Active-low output enable for the data bus |
| pkt_end_n | input | 1 | Active-low packet end, commits a short packet |
| thr_sel | input | AW (2) | Thread number |
| dq_in | input | DW (16) | Data bus as seen from the pad input |
| dq_out | output | DW (16) | Registered read word for the pad output |
| dq_drive | output | 1 | Pad output enable for the data bus |
| flag_a | output | 1 | Addressed thread not full |
| flag_b | output | 1 | Addressed thread not empty |
| flag_c | output | 1 | Thread 0 full |
| flag_d | output | 1 | Thread 1 empty |
| thr_err | output | NTHR (4) | Sticky per-thread overflow/underflow bits |
| pkt_rdy | output | NTHR (4) | Per-thread packet-ready bits |

## Verification
The bench writes interleaved bursts to two threads and reads them back. This separates per-thread ordering from a shared pointer or a thread-decode error. It fills thread 0 to its last entry and then one past it, which shows where the full boundary lies and whether the dropped word damages stored data. It also shows when `flag_c` and `flag_a` switch. Reads of an empty thread, strobes given with chip select high, and packet-end on empty, partly filled and deselected threads separate the error, ignore and commit paths from the normal push and pop.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2,
        ACC_BOTH  = 2'd3
    } acc_kind_e;

    function automatic acc_kind_e acc_kind(input logic wr, input logic rd);
        return acc_kind_e'({rd, wr});
    endfunction
endpackage

// File: rtl/sfifo_thread_buf.sv
module sfifo_thread_buf #(
    parameter int DW    = 16,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic          end_req,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          full_nx,
    output logic          empty_nx,
    output logic          err,
    output logic          rdy
);
    import sfifo_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          err;
        logic          rdy;
    } st_t;

    st_t st_q, st_d;
    logic [DW-1:0] mem [DEPTH];
    logic full, push, pop;
    acc_kind_e kind;

    always_comb begin
        full  = (st_q.cnt == CNT_FULL);
        empty = (st_q.cnt == '0);
        kind  = acc_kind(wr_req, rd_req);
        push  = (kind == ACC_WRITE || kind == ACC_BOTH) && !full;
        pop   = (kind == ACC_READ  || kind == ACC_BOTH) && !empty;
        st_d  = st_q;
        if (push) st_d.wp = (st_q.wp == PTR_LAST) ? '0 : st_q.wp + 1'b1;
        if (pop)  st_d.rp = (st_q.rp == PTR_LAST) ? '0 : st_q.rp + 1'b1;
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
        st_d.err = st_q.err | (wr_req & full) | (rd_req & empty);
        if (st_d.cnt == '0)
            st_d.rdy = 1'b0;
        else if (st_d.cnt == CNT_FULL || end_req)
            st_d.rdy = 1'b1;
        full_nx  = (st_d.cnt == CNT_FULL);
        empty_nx = (st_d.cnt == '0);
        rdata    = mem[st_q.rp];
        err      = st_q.err;
        rdy      = st_q.rdy;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wp] <= wdata;
    end

    // R11: occupancy never exceeds the configured depth
    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CNT_FULL);

    // R8: a lone write into a full thread leaves it full
    p_full_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_req && full && !rd_req) |=> (st_q.cnt == CNT_FULL));

    // R8/R9: error bit is sticky
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        st_q.err |=> st_q.err);

    // R9: a lone read from an empty thread keeps the read pointer
    p_empty_rp_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_req && empty && !wr_req) |=> $stable(st_q.rp));
endmodule

// File: rtl/sfifo_flag_unit.sv
module sfifo_flag_unit #(
    parameter int NTHR = 4,
    parameter int AW   = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sel_en,
    input  logic [AW-1:0]   sel,
    input  logic [NTHR-1:0] full_nx,
    input  logic [NTHR-1:0] empty_nx,
    output logic            flag_a,
    output logic            flag_b,
    output logic            flag_c,
    output logic            flag_d
);
    typedef struct packed {
        logic [AW-1:0] sel;
        logic          a;
        logic          b;
        logic          c;
        logic          d;
    } fl_t;

    fl_t fl_q, fl_d;

    always_comb begin
        fl_d     = fl_q;
        if (sel_en) fl_d.sel = sel;
        fl_d.a   = !full_nx[fl_d.sel];
        fl_d.b   = !empty_nx[fl_d.sel];
        fl_d.c   = full_nx[0];
        fl_d.d   = empty_nx[1];
    end

    always_ff @(posedge clk) begin
        if (rst) fl_q <= '{sel: '0, a: 1'b1, b: 1'b0, c: 1'b0, d: 1'b1};
        else     fl_q <= fl_d;
    end

    assign flag_a = fl_q.a;
    assign flag_b = fl_q.b;
    assign flag_c = fl_q.c;
    assign flag_d = fl_q.d;

    // R6: a thread can never be both full and empty
    p_flag_excl_r6: assert property (@(posedge clk) disable iff (rst)
        flag_a || flag_b);

    // R6: with chip select high the addressed thread is held
    p_sel_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !sel_en |=> $stable(fl_q.sel));
endmodule

// File: rtl/sfifo_port.sv
module sfifo_port #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int NTHR  = 4,
    parameter int AW    = $clog2(NTHR)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            wr_n,
    input  logic            rd_n,
    input  logic            oe_n,
    input  logic            pkt_end_n,
    input  logic [AW-1:0]   thr_sel,
    input  logic [DW-1:0]   dq_in,
    output logic [DW-1:0]   dq_out,
    output logic            dq_drive,
    output logic            flag_a,
    output logic            flag_b,
    output logic            flag_c,
    output logic            flag_d,
    output logic [NTHR-1:0] thr_err,
    output logic [NTHR-1:0] pkt_rdy
);
    typedef struct packed {
        logic [DW-1:0] rword;
    } rd_t;

    rd_t rd_q, rd_d;
    logic act;
    logic [NTHR-1:0] wr_req, rd_req, end_req, empty, full_nx, empty_nx;
    logic [DW-1:0] rdata_w [NTHR];

    assign act = !cs_n;

    for (genvar i = 0; i < NTHR; i++) begin : g_thr
        assign wr_req[i]  = act && !wr_n      && (thr_sel == AW'(i));
        assign rd_req[i]  = act && !rd_n      && (thr_sel == AW'(i));
        assign end_req[i] = act && !pkt_end_n && (thr_sel == AW'(i));

        sfifo_thread_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
            .clk      (clk),
            .rst      (rst),
            .wr_req   (wr_req[i]),
            .rd_req   (rd_req[i]),
            .end_req  (end_req[i]),
            .wdata    (dq_in),
            .rdata    (rdata_w[i]),
            .empty    (empty[i]),
            .full_nx  (full_nx[i]),
            .empty_nx (empty_nx[i]),
            .err      (thr_err[i]),
            .rdy      (pkt_rdy[i])
        );
    end

    sfifo_flag_unit #(.NTHR(NTHR), .AW(AW)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .sel_en   (act),
        .sel      (thr_sel),
        .full_nx  (full_nx),
        .empty_nx (empty_nx),
        .flag_a   (flag_a),
        .flag_b   (flag_b),
        .flag_c   (flag_c),
        .flag_d   (flag_d)
    );

    always_comb begin
        rd_d = rd_q;
        if (act && !rd_n && !empty[thr_sel]) rd_d.rword = rdata_w[thr_sel];
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= '0;
        else     rd_q <= rd_d;
    end

    assign dq_out   = rd_q.rword;
    assign dq_drive = act && !oe_n;

    // R9: a read of an empty thread keeps the output word
    p_underflow_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (act && !rd_n && empty[thr_sel]) |=> $stable(dq_out));

    // R2: nothing reaches the output word while deselected
    p_cs_ignore_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> $stable(dq_out));
endmodule

// File: tb/sfifo_port_tb_top.sv
module sfifo_port_tb_top;
    localparam int DW = 16;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, oe_n = 1'b1, pkt_end_n = 1'b1;
    logic [1:0] thr_sel = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic dq_drive, flag_a, flag_b, flag_c, flag_d;
    logic [3:0] thr_err, pkt_rdy;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sfifo_port #(.DW(DW), .DEPTH(DEPTH), .NTHR(4)) dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .oe_n(oe_n), .pkt_end_n(pkt_end_n), .thr_sel(thr_sel),
        .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive),
        .flag_a(flag_a), .flag_b(flag_b), .flag_c(flag_c), .flag_d(flag_d),
        .thr_err(thr_err), .pkt_rdy(pkt_rdy)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive one bus cycle at the falling edge, return just after the rising edge
    task automatic cyc(input logic cs, input logic wr, input logic rd, input logic oe,
                       input logic pe, input logic [1:0] sel, input logic [DW-1:0] d);
        @(negedge clk);
        cs_n = cs; wr_n = wr; rd_n = rd; oe_n = oe; pkt_end_n = pe;
        thr_sel = sel; dq_in = d;
        @(posedge clk);
        #1;
    endtask

    task automatic wr_word(input logic [1:0] sel, input logic [DW-1:0] d);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, sel, d);
    endtask

    task automatic rd_word(input logic [1:0] sel);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, sel, '0);
    endtask

    task automatic t_reset;
        chk("R1 flag_a", 32'(flag_a), 32'd1);
        chk("R1 flag_b", 32'(flag_b), 32'd0);
        chk("R1 flag_c", 32'(flag_c), 32'd0);
        chk("R1 flag_d", 32'(flag_d), 32'd1);
        chk("R1 thr_err", 32'(thr_err), 32'd0);
        chk("R1 pkt_rdy", 32'(pkt_rdy), 32'd0);
        chk("R1 dq_drive", 32'(dq_drive), 32'd0);
    endtask

    task automatic t_cs_ignore;
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 16'hBEEF);
        chk("R2 no drive while deselected", 32'(dq_drive), 32'd0);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, '0);
        chk("R2 ignored write left thread0 empty", 32'(flag_b), 32'd0);
        chk("R2 ignored write no error", 32'(thr_err), 32'd0);
    endtask

    task automatic t_write_read;
        wr_word(2'd2, 16'hA001);
        wr_word(2'd3, 16'hB001);
        wr_word(2'd2, 16'hA002);
        wr_word(2'd3, 16'hB002);
        wr_word(2'd2, 16'hA003);
        chk("R6 flag_b after write", 32'(flag_b), 32'd1);
        chk("R6 flag_a after write", 32'(flag_a), 32'd1);
        for (int k = 1; k <= 3; k++) begin
            rd_word(2'd2);
            chk("R4 thread2 order", 32'(dq_out), 32'(16'hA000 + k));
            chk("R5 drive during read", 32'(dq_drive), 32'd1);
        end
        chk("R6 flag_b after drain", 32'(flag_b), 32'd0);
        for (int k = 1; k <= 2; k++) begin
            rd_word(2'd3);
            chk("R3 thread3 order", 32'(dq_out), 32'(16'hB000 + k));
        end
    endtask

    task automatic t_oe;
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd3, '0);
        chk("R5 oe high no drive", 32'(dq_drive), 32'd0);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3, '0);
        chk("R5 oe low drive", 32'(dq_drive), 32'd1);
        chk("R5 word held", 32'(dq_out), 32'h0000B002);
    endtask

    task automatic t_underflow;
        rd_word(2'd3);
        chk("R9 dq_out unchanged", 32'(dq_out), 32'h0000B002);
        chk("R9 error bit thread3", 32'(thr_err), 32'h8);
    endtask

    task automatic t_full;
        wr_word(2'd1, 16'h1111);
        chk("R7 flag_d thread1 not empty", 32'(flag_d), 32'd0);
        for (int k = 0; k < DEPTH; k++) begin
            wr_word(2'd0, 16'(16'h0100 + k));
            if (k == DEPTH - 2) begin
                chk("R11 not full one short", 32'(flag_c), 32'd0);
                chk("R6 flag_a one short", 32'(flag_a), 32'd1);
            end
        end
        chk("R7 flag_c thread0 full", 32'(flag_c), 32'd1);
        chk("R6 flag_a full", 32'(flag_a), 32'd0);
        chk("R10 full packet ready", 32'(pkt_rdy), 32'h1);
        wr_word(2'd0, 16'hDEAD);
        chk("R8 overflow error", 32'(thr_err), 32'h9);
        for (int k = 0; k < DEPTH; k++) begin
            rd_word(2'd0);
            chk("R8 contents intact", 32'(dq_out), 32'(16'h0100 + k));
            if (k == 0) chk("R7 flag_c clears", 32'(flag_c), 32'd0);
        end
        chk("R10 ready clears on empty", 32'(pkt_rdy), 32'h0);
        chk("R8 error sticky", 32'(thr_err), 32'h9);
    endtask

    task automatic t_pktend;
        wr_word(2'd2, 16'hC001);
        wr_word(2'd2, 16'hC002);
        chk("R10 not ready before end", 32'(pkt_rdy), 32'h0);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, '0);
        chk("R10 short packet committed", 32'(pkt_rdy), 32'h4);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3, '0);
        chk("R10 end on empty thread", 32'(pkt_rdy), 32'h4);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, '0);
        chk("R2 end ignored while deselected", 32'(pkt_rdy), 32'h4);
        rd_word(2'd2);
        rd_word(2'd2);
        chk("R10 drained", 32'(pkt_rdy), 32'h0);
        chk("R4 last short word", 32'(dq_out), 32'h0000C002);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_cs_ignore();
        t_write_read();
        t_oe();
        t_underflow();
        t_full();
        t_pktend();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule